// File: doc/BRIEF.md
# First-Error Tracking Control Register

This block keeps the uncorrectable error status vector of a link controller together with the control word that reports which of those errors arrived first. Each error type has one detect input. A detect sets the matching status bit, and software clears status bits by writing ones. A first-error pointer records the index of the earliest error. Once it captures a value it holds that value for as long as the status bit it indexes stays set. When software clears that bit, the pointer re-arms and the next error that newly sets a status bit is captured. While an emulation enable is asserted, firmware can load the pointer directly.

The same control word holds the end-to-end CRC generate and check capability and enable bits. The two capability bits are read-only to software, but a local management port can rewrite them. The two enable bits are software read/write and drive the transmit-generate and receive-check enable outputs. A single flag records whether a prefix log accompanied the captured error, and it reads as set only while the pointer is valid.

The block has two synchronous resets. The full reset clears everything. The non-sticky reset restores only the capability bits and leaves the pointer, the enables, the prefix flag and the status vector untouched.

Top module: `uerr_first_track`

## Requirements
- R1: A detect on bit i sets status bit i at the next clock edge. A one written to bit i with `sw_sel`=1 clears it. If a detect and a clear hit the same bit in the same cycle, the bit stays set. The status vector reads back on `sw_rdata` when `sw_sel`=1.
- R2: While the status bit indexed by the pointer is set, the pointer does not change, even when other error types set further status bits. The two exceptions are the firmware load of R6 and the same-cycle clear of R4.
- R3: While the indexed status bit is clear, the pointer loads the index of the next detect that newly sets a status bit. If several bits are newly set in one cycle, the lowest index wins. A detect on a bit that is already set does not count as newly set. Every bit position is treated alike, including error types that are reported through a correctable-error message.
- R4: Suppose software clears the indexed status bit in the same cycle that a different error is newly detected. The pointer then captures the new error's index in that cycle.
- R5: The non-sticky reset `rst_soft` leaves the pointer, both CRC enables, the prefix flag and the status vector unchanged. The full reset `rst_full` sets the pointer to 0, clears both enables and clears all status bits.
- R6: With `emu_en`=1, a pulse on `fw_ptr_wr` loads `fw_ptr_data` into the pointer at the next edge, and this takes priority over a capture. With `emu_en`=0, `fw_ptr_wr` has no effect.
- R7: The generate capability (control bit 5) and the check capability (control bit 7) become 1 on either reset. Software writes to these bits are ignored. A write on the management port loads them from `mgmt_wdata[5]` and `mgmt_wdata[7]`.
- R8: The generate enable (control bit 6) and the check enable (control bit 8) reset to 0. Software loads them from `sw_wdata[6]` and `sw_wdata[8]` with `sw_sel`=0, and the management port loads them from `mgmt_wdata[6]` and `mgmt_wdata[8]`. If both ports write in the same cycle, the management write wins. The enables drive `tx_ecrc_gen_en` and `rx_ecrc_chk_en`.
- R9: With `sw_sel`=0, `sw_rdata` returns the control word. The pointer sits in bits 4:0. Bits 9 and 10 (multiple header recording capable and enable) read 0, and bits 31:12 read 0. Writes to these bits are ignored.
- R10: On each capture, control bit 11 (prefix log present) loads `err_prefix_logged`. It reads 1 only while the pointer is valid. The pointer is valid when the status bit it indexes is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_full | input | 1 | Synchronous full reset, active high |
| rst_soft | input | 1 | Synchronous non-sticky reset, active high |
| err_detect | input | NUM_ERR (32) | One detect pulse per uncorrectable error type |
| err_prefix_logged | input | 1 | A prefix log accompanies the error being captured |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0 selects the control word, 1 selects the status vector |
| sw_wdata | input | 32 | Software write data (write-one-to-clear for status) |
| sw_rdata | output | 32 | Software read data for the selected word |
| mgmt_wr | input | 1 | Management port write strobe |
| mgmt_wdata | input | 32 | Management write data (bits 8:5 used) |
| emu_en | input | 1 | Error emulation enable |
| fw_ptr_wr | input | 1 | Firmware pointer load strobe |
| fw_ptr_data | input | PTR_W (5) | Firmware pointer value |
| first_err_ptr | output | PTR_W (5) | Current first-error pointer |
| first_err_valid | output | 1 | Status bit at the pointer index is set |
| tx_ecrc_gen_en | output | 1 | Transmit CRC generation enable |
| rx_ecrc_chk_en | output | 1 | Receive CRC check enable |

## Verification
The hardest case to reach is a cycle in which software clears the indexed status bit while a fresh error is detected at the same edge. It needs the pointer already captured and valid, a second error type already set in status, and then both the clear and a new detect driven in one cycle. The bench gets there in stages. It captures one error, freezes the pointer behind a second, re-arms by clearing, and captures a pair in the same cycle to check the lowest-index rule. It then drives the clear of that index together with a detect on a higher bit. It also covers three other cases: a detect on a bit that is already set while the pointer is re-armed, a firmware load that competes with a capture, and a management write that collides with a software write.

// File: rtl/uerr_pkg.sv
package uerr_pkg;

    localparam int ERR_MAX   = 32;
    localparam int PTR_FLD_W = 5;
    localparam int CTRL_W    = 32;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    // CRC capability and enable bits, in the order they sit in the control word
    typedef struct packed {
        logic chk_en;
        logic chk_cap;
        logic gen_en;
        logic gen_cap;
    } ecrc_bits_t;

    // Control word layout, most significant field first
    typedef struct packed {
        logic [19:0]          rsvd;
        logic                 prefix_vld;
        logic                 mh_en;
        logic                 mh_cap;
        ecrc_bits_t           ecrc;
        logic [PTR_FLD_W-1:0] ptr;
    } ctrl_word_t;

    function automatic ecrc_bits_t ecrc_from_word(input logic [CTRL_W-1:0] w);
        ecrc_bits_t b;
        b.gen_cap = w[5];
        b.gen_en  = w[6];
        b.chk_cap = w[7];
        b.chk_en  = w[8];
        return b;
    endfunction

    function automatic logic [PTR_FLD_W-1:0] lowest_set(input logic [ERR_MAX-1:0] v);
        logic [PTR_FLD_W-1:0] idx;
        idx = '0;
        for (int i = ERR_MAX - 1; i >= 0; i--) begin
            if (v[i]) idx = PTR_FLD_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/uerr_status_reg.sv
module uerr_status_reg #(
    parameter int NUM_ERR = 32
) (
    input  logic               clk,
    input  logic               rst_full,
    input  logic [NUM_ERR-1:0] err_detect,
    input  logic [NUM_ERR-1:0] clr_mask,
    output logic [NUM_ERR-1:0] status_q
);

    // Sticky: only the full reset clears status; a new detect beats a clear
    always_ff @(posedge clk) begin
        if (rst_full) status_q <= '0;
        else          status_q <= (status_q & ~clr_mask) | err_detect;
    end

endmodule

// File: rtl/uerr_first_ptr.sv
module uerr_first_ptr
    import uerr_pkg::*;
#(
    parameter int NUM_ERR = 32,
    parameter int PTR_W   = $clog2(NUM_ERR)
) (
    input  logic               clk,
    input  logic               rst_full,
    input  logic [NUM_ERR-1:0] status_q,
    input  logic [NUM_ERR-1:0] err_detect,
    input  logic [NUM_ERR-1:0] clr_mask,
    input  logic               fw_load,
    input  logic [PTR_W-1:0]   fw_ptr,
    input  logic               prefix_in,
    output logic [PTR_W-1:0]   ptr_q,
    output logic               prefix_q,
    output logic               ptr_valid
);

    logic [NUM_ERR-1:0] kept;
    logic [NUM_ERR-1:0] newly;
    logic [ERR_MAX-1:0] newly_ext;
    logic               armed;
    logic               capture;
    logic [PTR_W-1:0]   cap_idx;

    always_comb begin
        kept      = status_q & ~clr_mask;
        newly     = err_detect & ~kept;
        newly_ext = '0;
        newly_ext[NUM_ERR-1:0] = newly;
        ptr_valid = status_q[ptr_q];
        // re-armed when the indexed bit is clear, or is being cleared this cycle
        armed     = ~kept[ptr_q];
        capture   = armed & (|newly);
        cap_idx   = PTR_W'(lowest_set(newly_ext));
    end

    always_ff @(posedge clk) begin
        if (rst_full) begin
            ptr_q    <= '0;
            prefix_q <= 1'b0;
        end else if (fw_load) begin
            ptr_q    <= fw_ptr;
        end else if (capture) begin
            ptr_q    <= cap_idx;
            prefix_q <= prefix_in;
        end
    end

endmodule

// File: rtl/uerr_ecrc_ctl.sv
module uerr_ecrc_ctl
    import uerr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_full,
    input  logic       rst_soft,
    input  logic       sw_we,
    input  ecrc_bits_t sw_bits,
    input  logic       mgmt_we,
    input  ecrc_bits_t mgmt_bits,
    output ecrc_bits_t ecrc_q
);

    // Capability bits: non-sticky, restored by either reset
    always_ff @(posedge clk) begin
        if (rst_full || rst_soft) begin
            ecrc_q.gen_cap <= 1'b1;
            ecrc_q.chk_cap <= 1'b1;
        end else if (mgmt_we) begin
            ecrc_q.gen_cap <= mgmt_bits.gen_cap;
            ecrc_q.chk_cap <= mgmt_bits.chk_cap;
        end
    end

    // Enable bits: sticky, management port wins a same-cycle collision
    always_ff @(posedge clk) begin
        if (rst_full) begin
            ecrc_q.gen_en <= 1'b0;
            ecrc_q.chk_en <= 1'b0;
        end else if (mgmt_we) begin
            ecrc_q.gen_en <= mgmt_bits.gen_en;
            ecrc_q.chk_en <= mgmt_bits.chk_en;
        end else if (sw_we) begin
            ecrc_q.gen_en <= sw_bits.gen_en;
            ecrc_q.chk_en <= sw_bits.chk_en;
        end
    end

endmodule

// File: rtl/uerr_first_track.sv
module uerr_first_track
    import uerr_pkg::*;
#(
    parameter int NUM_ERR = 32,
    localparam int PTR_W  = $clog2(NUM_ERR)
) (
    input  logic               clk,
    input  logic               rst_full,
    input  logic               rst_soft,
    input  logic [NUM_ERR-1:0] err_detect,
    input  logic               err_prefix_logged,
    input  logic               sw_wr,
    input  logic               sw_sel,
    input  logic [CTRL_W-1:0]  sw_wdata,
    output logic [CTRL_W-1:0]  sw_rdata,
    input  logic               mgmt_wr,
    input  logic [CTRL_W-1:0]  mgmt_wdata,
    input  logic               emu_en,
    input  logic               fw_ptr_wr,
    input  logic [PTR_W-1:0]   fw_ptr_data,
    output logic [PTR_W-1:0]   first_err_ptr,
    output logic               first_err_valid,
    output logic               tx_ecrc_gen_en,
    output logic               rx_ecrc_chk_en
);

    reg_sel_e           sel;
    logic [NUM_ERR-1:0] clr_mask;
    logic [NUM_ERR-1:0] status_q;
    logic [PTR_W-1:0]   ptr_q;
    logic               prefix_q;
    logic               ptr_valid;
    logic               sw_ctrl_we;
    logic               fw_load;
    ecrc_bits_t         ecrc_q;
    ctrl_word_t         ctrl_w;
    logic               unused_wbits;

    assign sel        = reg_sel_e'(sw_sel);
    assign sw_ctrl_we = sw_wr && (sel == SEL_CTRL);
    assign clr_mask   = (sw_wr && (sel == SEL_STAT)) ? sw_wdata[NUM_ERR-1:0] : '0;
    assign fw_load    = emu_en && fw_ptr_wr;
    assign unused_wbits = ^{mgmt_wdata[CTRL_W-1:9], mgmt_wdata[4:0],
                            sw_wdata[CTRL_W-1:9], sw_wdata[4:0]};

    uerr_status_reg #(.NUM_ERR(NUM_ERR)) u_status (
        .clk        (clk),
        .rst_full   (rst_full),
        .err_detect (err_detect),
        .clr_mask   (clr_mask),
        .status_q   (status_q)
    );

    uerr_first_ptr #(.NUM_ERR(NUM_ERR), .PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst_full   (rst_full),
        .status_q   (status_q),
        .err_detect (err_detect),
        .clr_mask   (clr_mask),
        .fw_load    (fw_load),
        .fw_ptr     (fw_ptr_data),
        .prefix_in  (err_prefix_logged),
        .ptr_q      (ptr_q),
        .prefix_q   (prefix_q),
        .ptr_valid  (ptr_valid)
    );

    uerr_ecrc_ctl u_ecrc (
        .clk        (clk),
        .rst_full   (rst_full),
        .rst_soft   (rst_soft),
        .sw_we      (sw_ctrl_we),
        .sw_bits    (ecrc_from_word(sw_wdata)),
        .mgmt_we    (mgmt_wr),
        .mgmt_bits  (ecrc_from_word(mgmt_wdata)),
        .ecrc_q     (ecrc_q)
    );

    always_comb begin
        ctrl_w            = '0;
        ctrl_w.ptr        = PTR_FLD_W'(ptr_q);
        ctrl_w.ecrc       = ecrc_q;
        ctrl_w.prefix_vld = prefix_q & ptr_valid;
        sw_rdata = (sel == SEL_STAT) ? CTRL_W'(status_q) : ctrl_w;
    end

    assign first_err_ptr   = ptr_q;
    assign first_err_valid = ptr_valid;
    assign tx_ecrc_gen_en  = ecrc_q.gen_en;
    assign rx_ecrc_chk_en  = ecrc_q.chk_en;

endmodule

// File: rtl/uerr_first_track_chk.sv
module uerr_first_track_chk #(
    parameter int NUM_ERR = 32,
    parameter int PTR_W   = $clog2(NUM_ERR)
) (
    input logic               clk,
    input logic               rst_full,
    input logic               rst_soft,
    input logic [NUM_ERR-1:0] err_detect,
    input logic               sw_wr,
    input logic               sw_sel,
    input logic [31:0]        sw_wdata,
    input logic [31:0]        sw_rdata,
    input logic               mgmt_wr,
    input logic               emu_en,
    input logic               fw_ptr_wr,
    input logic [PTR_W-1:0]   fw_ptr_data,
    input logic [NUM_ERR-1:0] status_q,
    input logic [PTR_W-1:0]   first_err_ptr,
    input logic               first_err_valid,
    input logic               gen_cap,
    input logic               chk_cap,
    input logic               tx_ecrc_gen_en,
    input logic               rx_ecrc_chk_en
);

    logic [NUM_ERR-1:0] clr_c;
    logic [NUM_ERR-1:0] newly_c;
    logic               fw_hit;
    logic               clr_ptr;
    logic               rearmed;

    always_comb begin
        clr_c   = (sw_wr && sw_sel) ? sw_wdata[NUM_ERR-1:0] : '0;
        newly_c = err_detect & ~(status_q & ~clr_c);
        fw_hit  = emu_en && fw_ptr_wr;
        clr_ptr = clr_c[first_err_ptr];
        rearmed = !first_err_valid || clr_ptr;
    end

    AST_STATUS_SET: assert property (@(posedge clk) disable iff (rst_full)
        (|err_detect) |=> ((status_q & $past(err_detect)) == $past(err_detect))); // R1

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst_full)
        (first_err_valid && !clr_ptr && !fw_hit) |=> $stable(first_err_ptr)); // R2

    AST_REARM_CAPTURE: assert property (@(posedge clk) disable iff (rst_full)
        (rearmed && (|newly_c) && !fw_hit) |=> first_err_valid); // R3

    AST_CLEAR_RACE: assert property (@(posedge clk) disable iff (rst_full)
        (first_err_valid && clr_ptr && (|newly_c) && !fw_hit) |=> first_err_valid); // R4

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst_full)
        (rst_soft && !fw_hit && !(|err_detect) && !sw_wr && !mgmt_wr)
        |=> ($stable(first_err_ptr) && $stable(status_q)
             && $stable(tx_ecrc_gen_en) && $stable(rx_ecrc_chk_en))); // R5

    AST_FW_LOAD: assert property (@(posedge clk) disable iff (rst_full)
        fw_hit |=> (first_err_ptr == $past(fw_ptr_data))); // R6

    AST_CAP_RESTORE: assert property (@(posedge clk) disable iff (rst_full)
        rst_soft |=> (gen_cap && chk_cap)); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst_full)
        !sw_sel |-> (sw_rdata[31:12] == 20'd0 && sw_rdata[10:9] == 2'b00)); // R9

    AST_PREFIX_MASK: assert property (@(posedge clk) disable iff (rst_full)
        (!sw_sel && !first_err_valid) |-> !sw_rdata[11]); // R10

endmodule

bind uerr_first_track uerr_first_track_chk #(.NUM_ERR(NUM_ERR), .PTR_W(PTR_W)) u_chk (
    .clk             (clk),
    .rst_full        (rst_full),
    .rst_soft        (rst_soft),
    .err_detect      (err_detect),
    .sw_wr           (sw_wr),
    .sw_sel          (sw_sel),
    .sw_wdata        (sw_wdata),
    .sw_rdata        (sw_rdata),
    .mgmt_wr         (mgmt_wr),
    .emu_en          (emu_en),
    .fw_ptr_wr       (fw_ptr_wr),
    .fw_ptr_data     (fw_ptr_data),
    .status_q        (status_q),
    .first_err_ptr   (first_err_ptr),
    .first_err_valid (first_err_valid),
    .gen_cap         (ecrc_q.gen_cap),
    .chk_cap         (ecrc_q.chk_cap),
    .tx_ecrc_gen_en  (tx_ecrc_gen_en),
    .rx_ecrc_chk_en  (rx_ecrc_chk_en)
);

// File: tb/tb_uerr_first_track.sv
module tb_uerr_first_track;

    logic        clk = 1'b0;
    logic        rst_full, rst_soft;
    logic [31:0] err_detect;
    logic        err_prefix_logged;
    logic        sw_wr, sw_sel;
    logic [31:0] sw_wdata, sw_rdata;
    logic        mgmt_wr;
    logic [31:0] mgmt_wdata;
    logic        emu_en, fw_ptr_wr;
    logic [4:0]  fw_ptr_data, first_err_ptr;
    logic        first_err_valid, tx_ecrc_gen_en, rx_ecrc_chk_en;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    uerr_first_track dut (
        .clk(clk), .rst_full(rst_full), .rst_soft(rst_soft),
        .err_detect(err_detect), .err_prefix_logged(err_prefix_logged),
        .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .mgmt_wr(mgmt_wr), .mgmt_wdata(mgmt_wdata),
        .emu_en(emu_en), .fw_ptr_wr(fw_ptr_wr), .fw_ptr_data(fw_ptr_data),
        .first_err_ptr(first_err_ptr), .first_err_valid(first_err_valid),
        .tx_ecrc_gen_en(tx_ecrc_gen_en), .rx_ecrc_chk_en(rx_ecrc_chk_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rst_soft = 0; err_detect = '0; err_prefix_logged = 0;
        sw_wr = 0; sw_sel = 0; sw_wdata = '0;
        mgmt_wr = 0; mgmt_wdata = '0; fw_ptr_wr = 0; fw_ptr_data = '0;
    endtask

    // one clock edge, then back at the falling edge with inputs idle
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        sw_sel = sel;
        #1;
        v = sw_rdata;
        sw_sel = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_full = 1; emu_en = 0; idle();
        step(); step();
        rst_full = 0;
        rd(0, v); check("R7 R9 reset ctrl word", v, 32'h0000_00A0);
        rd(1, v); check("R5 reset status", v, 32'h0);
        check("R8 reset enables", {tx_ecrc_gen_en, rx_ecrc_chk_en}, 0);
        check("R5 reset pointer", first_err_ptr, 0);
    endtask

    task automatic t_first_capture();
        logic [31:0] v;
        err_detect = 32'h80; err_prefix_logged = 1; step();
        rd(1, v); check("R1 detect sets status", v, 32'h80);
        check("R3 capture index 7", first_err_ptr, 7);
        rd(0, v); check("R10 prefix flag while valid", v, 32'h0000_08A7);
    endtask

    task automatic t_frozen();
        err_detect = 32'h8; step();
        check("R2 pointer frozen", first_err_ptr, 7);
    endtask

    task automatic t_rearm();
        logic [31:0] v;
        sw_wr = 1; sw_sel = 1; sw_wdata = 32'h80; step();
        check("R3 pointer kept after clear", first_err_ptr, 7);
        check("R10 pointer invalid", first_err_valid, 0);
        rd(0, v); check("R10 prefix masked when invalid", v, 32'h0000_00A7);
        err_detect = 32'h8; step();
        check("R3 already-set bit not captured", first_err_ptr, 7);
        err_detect = 32'h0010_1000; step();
        check("R3 lowest of simultaneous", first_err_ptr, 12);
        rd(1, v); check("R1 status after pair", v, 32'h0010_1008);
        rd(0, v); check("R10 prefix 0 captured", v, 32'h0000_00AC);
    endtask

    task automatic t_race();
        logic [31:0] v;
        sw_wr = 1; sw_sel = 1; sw_wdata = 32'h1000;
        err_detect = 32'h0200_0000; err_prefix_logged = 1; step();
        check("R4 capture during clear", first_err_ptr, 25);
        rd(1, v); check("R4 status after race", v, 32'h0210_0008);
        rd(0, v); check("R4 R10 ctrl after race", v, 32'h0000_08B9);
        sw_wr = 1; sw_sel = 1; sw_wdata = 32'h8; err_detect = 32'h8; step();
        rd(1, v); check("R1 set beats clear", v, 32'h0210_0008);
        check("R2 pointer held", first_err_ptr, 25);
    endtask

    task automatic t_firmware();
        logic [31:0] v;
        emu_en = 0; fw_ptr_wr = 1; fw_ptr_data = 5'd9; step();
        check("R6 fw write ignored without emulation", first_err_ptr, 25);
        emu_en = 1; fw_ptr_wr = 1; fw_ptr_data = 5'd9; step();
        check("R6 fw write loads pointer", first_err_ptr, 9);
        check("R6 loaded pointer invalid", first_err_valid, 0);
        fw_ptr_wr = 1; fw_ptr_data = 5'd2; err_detect = 32'h20; step();
        check("R6 fw beats capture", first_err_ptr, 2);
        emu_en = 0;
        rd(1, v); check("R1 status after fw", v, 32'h0210_0028);
    endtask

    task automatic t_ecrc();
        logic [31:0] v;
        sw_wr = 1; sw_sel = 0; sw_wdata = 32'hFFFF_FFFF; step();
        rd(0, v); check("R8 R9 sw write all ones", v, 32'h0000_01E2);
        check("R8 enable outputs set", {tx_ecrc_gen_en, rx_ecrc_chk_en}, 2'b11);
        mgmt_wr = 1; mgmt_wdata = 32'h0; step();
        rd(0, v); check("R7 mgmt clears caps", v, 32'h0000_0002);
        mgmt_wr = 1; mgmt_wdata = 32'h20; sw_wr = 1; sw_wdata = 32'h140; step();
        rd(0, v); check("R8 mgmt wins collision", v, 32'h0000_0022);
        sw_wr = 1; sw_wdata = 32'hA0; step();
        rd(0, v); check("R7 sw cap write ignored", v, 32'h0000_0022);
        sw_wr = 1; sw_wdata = 32'h140; step();
        rd(0, v); check("R8 sw sets enables", v, 32'h0000_0162);
        check("R8 enable outputs", {tx_ecrc_gen_en, rx_ecrc_chk_en}, 2'b11);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        rst_soft = 1; step();
        rd(0, v); check("R5 R7 ctrl after soft reset", v, 32'h0000_01E2);
        rd(1, v); check("R5 status after soft reset", v, 32'h0210_0028);
    endtask

    task automatic t_full_reset();
        logic [31:0] v;
        rst_full = 1; step();
        rst_full = 0;
        rd(0, v); check("R5 ctrl after full reset", v, 32'h0000_00A0);
        rd(1, v); check("R5 status after full reset", v, 32'h0);
        check("R5 outputs after full reset", {tx_ecrc_gen_en, rx_ecrc_chk_en}, 0);
    endtask

    initial begin
        t_reset();
        t_first_capture();
        t_frozen();
        t_rearm();
        t_race();
        t_firmware();
        t_ecrc();
        t_soft_reset();
        t_full_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL all watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule